// File: doc/BRIEF.md
# Programmable Clock Pulse Squasher

This block reduces the rate of a fast clock by passing only some of its cycles. Each pass or drop decision comes from a programmable 16-bit keep pattern. The block produces a per-cycle clock enable, `clk_en`, that downstream logic or a clock-gating cell can qualify on. It also produces a complementary drop indication and a window-start marker.

Software writes a control word through a single-cycle strobe. The word has an enable bit, a window-length field holding the length minus one, and the keep pattern. Only the top "window length" bits of the pattern take part. They are used most significant bit first, one bit per input cycle, and the window repeats without a gap.

A written word waits in a holding register and becomes active only at a window boundary, so no window ever mixes two patterns. When the enable bit is clear, or the pattern is all zeros, the block is in bypass and every cycle passes. A readback pair reports how many cycles are kept per window and how long the window is. Their ratio is the output-to-input frequency ratio.

Top module: `pulse_squasher`

## Requirements
- R1: While `rst_n` is low, and until the second rising clock edge after it rises, the block is in bypass: `clk_en`=1, `win_start`=1, `rate_ones`=1 and `rate_len`=1. Any pending word is discarded.
- R2: With the active enable bit at 0, `clk_en` is 1 on every cycle, whatever pattern is stored.
- R3: With the enable bit at 1 and an all-zero pattern, the block is in bypass exactly as in R2.
- R4: When squashing, the window is `cfg_win_m1`+1 cycles long. `win_start` is 1 on the first cycle of each window, and windows follow one another with no gap. In bypass, `win_start` is 1 on every cycle.
- R5: On cycle k of a window (k = 0 first), `clk_en` equals pattern bit [15−k]. Pattern bits below the active window never affect the output.
- R6: `pulse_drop` is 1 exactly on the cycles where `clk_en` is 0.
- R7: `rate_len` is `cfg_win_m1`+1 when squashing and 1 in bypass. `rate_ones` is the number of ones in the top `rate_len` bits of the pattern when squashing, and 1 in bypass.
- R8: A word written with `cfg_wr`=1 at clock edge t is held as pending. It becomes active at the first later edge that ends a window, and the window counter restarts at 0 at that edge. A newer write before that edge replaces the pending word.
- R9: Pattern 0xFFFF with a 16-cycle window keeps every cycle, giving full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | One-cycle strobe that captures the control word |
| cfg_enable | input | 1 | Squash enable bit of the control word |
| cfg_win_m1 | input | 4 | Window length minus one |
| cfg_wave | input | 16 | Keep pattern, MSB used first |
| clk_en | output | 1 | 1 on cycles that pass |
| pulse_drop | output | 1 | 1 on cycles that are squashed |
| win_start | output | 1 | 1 on the first cycle of a window |
| rate_ones | output | 5 | Kept cycles per window |
| rate_len | output | 5 | Window length in cycles |

## Verification
On every cycle the assertions check the following: bypass keeps every cycle whether it comes from the enable bit or a zero pattern; a full pattern keeps every cycle; the window counter stays inside the window and wraps to a window start; the active word never changes in the middle of a window; and the reported kept count never exceeds the window length. Only the bench scenarios can show that the pass/drop sequence follows the pattern bit by bit, that low pattern bits outside a short window are ignored, and that a pair of back-to-back writes resolves to the last one at the right boundary. They also show that the readback values match each programmed pattern and that a reset during squashing returns the block to bypass.

// File: rtl/squash_pkg.sv
`timescale 1ns/1ps
package squash_pkg;
  parameter int SQ_WAVE_W = 16;
  localparam int SQ_CNT_W  = $clog2(SQ_WAVE_W);
  localparam int SQ_RATE_W = SQ_CNT_W + 1;

  typedef struct packed {
    logic                 en;
    logic [SQ_CNT_W-1:0]  win_m1;
    logic [SQ_WAVE_W-1:0] wave;
  } sq_ctl_t;

  localparam sq_ctl_t SQ_CTL_BYPASS = '{en: 1'b0, win_m1: '0, wave: '0};
endpackage

// File: rtl/sq_cfg_hold.sv
`timescale 1ns/1ps
module sq_cfg_hold
  import squash_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_i,
  input  sq_ctl_t wr_ctl_i,
  input  logic    boundary_i,
  output sq_ctl_t act_o
);

  sq_ctl_t pend_q;
  sq_ctl_t act_q;
  logic    pend_v_q;
  logic    pend_v_d;
  logic    take;

  // next-state
  always_comb begin
    take     = boundary_i && pend_v_q;
    pend_v_d = wr_i || (pend_v_q && !take);
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= SQ_CTL_BYPASS;
      act_q    <= SQ_CTL_BYPASS;
      pend_v_q <= 1'b0;
    end else begin
      pend_v_q <= pend_v_d;
      if (wr_i) pend_q <= wr_ctl_i;
      if (take) act_q  <= pend_q;
    end
  end

  assign act_o = act_q;

  AST_ACT_HELD_MIDWINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> $stable(act_q)); // R8

endmodule

// File: rtl/sq_window_walk.sv
`timescale 1ns/1ps
module sq_window_walk
  import squash_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sq_ctl_t act_i,
  output logic    keep_o,
  output logic    boundary_o,
  output logic    win_start_o
);

  logic                squash;
  logic [SQ_CNT_W-1:0] last_idx;
  logic [SQ_CNT_W-1:0] cnt_q;
  logic [SQ_CNT_W-1:0] cnt_d;
  logic [SQ_CNT_W-1:0] bit_idx;

  always_comb begin
    squash      = act_i.en && (act_i.wave != '0);
    last_idx    = squash ? act_i.win_m1 : '0;
    boundary_o  = (cnt_q == last_idx);
    cnt_d       = boundary_o ? '0 : cnt_q + 1'b1;
    bit_idx     = SQ_CNT_W'(SQ_WAVE_W - 1) - cnt_q;
    keep_o      = !squash || act_i.wave[bit_idx];
    win_start_o = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_i.win_m1); // R4

  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_o |=> win_start_o); // R4

endmodule

// File: rtl/sq_rate_report.sv
`timescale 1ns/1ps
module sq_rate_report
  import squash_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  sq_ctl_t              act_i,
  output logic [SQ_RATE_W-1:0] ones_o,
  output logic [SQ_RATE_W-1:0] len_o
);

  logic                 squash;
  logic [SQ_CNT_W-1:0]  low_edge;
  logic [SQ_WAVE_W-1:0] in_win;
  logic [SQ_RATE_W-1:0] ones_sum;

  assign low_edge = SQ_CNT_W'(SQ_WAVE_W - 1) - act_i.win_m1;

  for (genvar gi = 0; gi < SQ_WAVE_W; gi++) begin : g_mask
    assign in_win[gi] = (SQ_CNT_W'(gi) >= low_edge) && act_i.wave[gi];
  end

  always_comb begin
    squash   = act_i.en && (act_i.wave != '0);
    ones_sum = '0;
    for (int i = 0; i < SQ_WAVE_W; i++) begin
      ones_sum = ones_sum + SQ_RATE_W'(in_win[i]);
    end
    ones_o = squash ? ones_sum : SQ_RATE_W'(1);
    len_o  = squash ? ({1'b0, act_i.win_m1} + 1'b1) : SQ_RATE_W'(1);
  end

  AST_ONES_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ones_o <= len_o); // R7

endmodule

// File: rtl/pulse_squasher.sv
`timescale 1ns/1ps
module pulse_squasher
  import squash_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_enable,
  input  logic [SQ_CNT_W-1:0]  cfg_win_m1,
  input  logic [SQ_WAVE_W-1:0] cfg_wave,
  output logic                 clk_en,
  output logic                 pulse_drop,
  output logic                 win_start,
  output logic [SQ_RATE_W-1:0] rate_ones,
  output logic [SQ_RATE_W-1:0] rate_len
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;
  sq_ctl_t                wr_ctl;
  sq_ctl_t                act;
  logic                   keep;
  logic                   boundary;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  assign wr_ctl = '{en: cfg_enable, win_m1: cfg_win_m1, wave: cfg_wave};

  sq_cfg_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_i       (cfg_wr),
    .wr_ctl_i   (wr_ctl),
    .boundary_i (boundary),
    .act_o      (act)
  );

  sq_window_walk u_walk (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .act_i       (act),
    .keep_o      (keep),
    .boundary_o  (boundary),
    .win_start_o (win_start)
  );

  sq_rate_report u_rate (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .act_i  (act),
    .ones_o (rate_ones),
    .len_o  (rate_len)
  );

  assign clk_en     = keep;
  assign pulse_drop = !keep;

  AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (!rst_core_n)
    !act.en |-> clk_en); // R2

  AST_ZERO_WAVE_PASSES: assert property (@(posedge clk) disable iff (!rst_core_n)
    (act.wave == '0) |-> clk_en); // R3

  AST_FULL_WAVE_PASSES: assert property (@(posedge clk) disable iff (!rst_core_n)
    (act.en && (&act.wave)) |-> clk_en); // R9

endmodule

// File: tb/pulse_squasher_test.sv
`timescale 1ns/1ps
module pulse_squasher_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic        cfg_enable;
  logic [3:0]  cfg_win_m1;
  logic [15:0] cfg_wave;
  logic        clk_en;
  logic        pulse_drop;
  logic        win_start;
  logic [4:0]  rate_ones;
  logic [4:0]  rate_len;

  pulse_squasher uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_enable (cfg_enable),
    .cfg_win_m1 (cfg_win_m1),
    .cfg_wave   (cfg_wave),
    .clk_en     (clk_en),
    .pulse_drop (pulse_drop),
    .win_start  (win_start),
    .rate_ones  (rate_ones),
    .rate_len   (rate_len)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit    keep;
    bit    ws;
    int    ones;
    int    len;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_tag  = "R1";
  bit    done     = 1'b0;

  // reference state built from the requirements
  bit       a_en, p_en, pv, rs1, rs2;
  bit [3:0] a_m1, p_m1, cnt;
  bit [15:0] a_wv, p_wv;

  task automatic chk(string req, string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // predictor: pushes the expected outputs for the current cycle
  always @(negedge clk) begin
    exp_t e;
    bit   sq;
    bit   bnd;
    bit   take;
    int   ln;
    if (!rst_n) begin
      a_en = 0; a_m1 = 0; a_wv = 0; p_en = 0; p_m1 = 0; p_wv = 0;
      pv = 0; cnt = 0; rs1 = 0; rs2 = 0;
    end
    sq     = a_en && (a_wv != 0);
    ln     = sq ? int'(a_m1) + 1 : 1;
    e.keep = !sq || a_wv[15 - cnt];
    e.ws   = (cnt == 0);
    e.len  = ln;
    e.ones = 0;
    for (int i = 16 - ln; i < 16; i++) e.ones += a_wv[i];
    if (!sq) e.ones = 1;
    e.tag  = cur_tag;
    sb_q.push_back(e);
    if (rst_n) begin
      if (rs2) begin
        bnd  = (cnt == (sq ? a_m1 : 4'd0));
        take = bnd && pv;
        cnt  = bnd ? 4'd0 : cnt + 4'd1;
        if (take) begin a_en = p_en; a_m1 = p_m1; a_wv = p_wv; end
        pv = cfg_wr || (pv && !take);
        if (cfg_wr) begin p_en = cfg_enable; p_m1 = cfg_win_m1; p_wv = cfg_wave; end
      end
      rs2 = rs1;
      rs1 = 1'b1;
    end
  end

  // monitor: pops and compares
  always @(negedge clk) begin
    exp_t e;
    #1;
    if (!done && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk(e.tag, "clk_en", int'(clk_en), int'(e.keep));
      chk("R6", "pulse_drop", int'(pulse_drop), int'(!e.keep));
      chk("R4", "win_start", int'(win_start), int'(e.ws));
      chk("R7", "rate_ones", int'(rate_ones), e.ones);
      chk("R7", "rate_len", int'(rate_len), e.len);
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic write_ctl(bit en, bit [3:0] m1, bit [15:0] wv);
    @(posedge clk); #2;
    cfg_wr = 1'b1; cfg_enable = en; cfg_win_m1 = m1; cfg_wave = wv;
    @(posedge clk); #2;
    cfg_wr = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #3000000;
    n_fails++;
    $display("FAIL watchdog run did not finish");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_enable = 1'b0; cfg_win_m1 = '0; cfg_wave = '0;
    idle(4); #2 rst_n = 1'b1;
    idle(6);
    cur_tag = "R2"; write_ctl(1'b0, 4'hF, 16'h8888); idle(40);
    cur_tag = "R3"; write_ctl(1'b1, 4'hF, 16'h0000); idle(40);
    cur_tag = "R5"; write_ctl(1'b1, 4'hF, 16'h8888); idle(40);
    write_ctl(1'b1, 4'hF, 16'hAAAA); idle(40);
    write_ctl(1'b1, 4'hF, 16'hFEFE); idle(40);
    write_ctl(1'b1, 4'hF, 16'hFFFE); idle(40);
    cur_tag = "R9"; write_ctl(1'b1, 4'hF, 16'hFFFF); idle(40);
    cur_tag = "R5"; write_ctl(1'b1, 4'h4, 16'hA54A); idle(30);
    cur_tag = "R8"; write_ctl(1'b1, 4'hF, 16'h8888); idle(21);
    write_ctl(1'b1, 4'h7, 16'hFFFF);
    write_ctl(1'b1, 4'h3, 16'hC000); idle(40);
    write_ctl(1'b1, 4'h2, 16'h4000); idle(12);
    cur_tag = "R1"; write_ctl(1'b1, 4'hF, 16'h8888); idle(25);
    #5 rst_n = 1'b0; idle(3); #2 rst_n = 1'b1; idle(20);
    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule